// File: doc/BRIEF.md
# Sliding-window exponent encoder

This block turns a binary exponent into the token stream that a modular exponentiation sequencer consumes when it uses a sliding window of five bits. After a start pulse it walks the exponent from its top bit down to bit 0. It reads exactly one exponent bit per clock through a bit-address output, and the caller returns that bit combinationally. It writes the resulting tokens, one per clock at most, into an external token memory that is five bits wide.

A token is either a square-only step or a window. A square-only step has value 0. A window has an odd value of 1 to 31, and its length is the position of its most significant one plus one. When the scan meets a one bit, the encoder takes the longest string of at most five bits that starts at that bit and ends in a one bit. Any zeros that follow the last one inside the five-bit span become square-only tokens after the window token. Near bit 0 the span is cut short, so it never reaches below bit 0. The encoder runs alongside the odd-power precomputation, so it is sized to finish a few cycles after the last exponent bit is read.

Top module: `swx_encoder`

## Requirements
- R1: A start pulse is taken only while busy is low. From the following cycle, busy stays high until the run ends. A start pulse while busy is high has no effect on the addresses read or on the tokens written.
- R2: The cycle after an accepted start with effective length N > 0, exp_addr presents bit N-1. It then falls by one every cycle down to 0. One exponent bit is read per cycle, with no stall.
- R3: A zero exponent bit that is not inside a window produces a token with tok_data = 0 (square only).
- R4: A one bit opens a window that covers the longest bit string of at most 5 bits that starts there and ends in a one bit. The window token is that string's value: odd, from 1 to 31, with the string's first bit as the most significant set bit. Any zeros after its last one follow as square-only tokens.
- R5: Reading the tokens in write order and expanding each one (0 becomes the single bit 0, a value v becomes v written with its most significant set bit first) gives back exactly the N exponent bits, from bit N-1 down to bit 0.
- R6: tok_we pulses write one token per cycle. Within a run, tok_addr starts at 0 and rises by one for each write. Nothing is written while busy is low.
- R7: done is a one-cycle pulse, with busy low. It comes no later than N+8 cycles after the start cycle. While done is high, tok_count equals the number of tokens written in that run.
- R8: An exponent length of 0 writes no token and pulses done, with tok_count = 0.
- R9: A length above MAX_BITS is treated as MAX_BITS. The first address read is then MAX_BITS-1.
- R10: A window that starts within four bits of bit 0 is cut short at bit 0. For example, a 1-bit exponent of value 1 yields the token 1, and a 2-bit exponent of value 3 yields the token 3.
- R11: The square-only tokens that are owed but not yet written never number more than 4. A window token that is waiting behind them never overlaps a new window closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin encoding; taken only while idle |
| exp_len | input | 12 | Exponent length in bits, sampled at start |
| exp_addr | output | 11 | Address of the exponent bit being read |
| exp_bit | input | 1 | Exponent bit at exp_addr, same cycle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| tok_we | output | 1 | Token write strobe |
| tok_addr | output | 11 | Token memory write address |
| tok_data | output | 5 | Token value: 0 square only, odd value a window |
| tok_count | output | 12 | Tokens written in the current or last run |

## Verification
The bench builds the block with its default MAX_BITS of 2048 and a window of 5. This lets a full-length exponent, and an oversize length that must clamp, run within the cycle budget. Short exponents of 1 to 7 bits reach the cut-off window at bit 0 and the window token that is held behind owed squares. Random exponents of several hundred bits cover every ordering of windows, trailing zeros and plain zeros. Each of these runs is checked token by token against a queue model, and the tokens are expanded back into the exponent.

// File: rtl/swx_pkg.sv
package swx_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_DRAIN = 2'd2
    } scan_st_e;

endpackage

// File: rtl/swx_scan.sv
module swx_scan
    import swx_pkg::*;
#(
    parameter int MAX_BITS = 2048,
    parameter int LEN_W    = $clog2(MAX_BITS + 1),
    parameter int ADDR_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              quiet_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_en_o,
    output logic              rd_last_o,
    output logic              launch_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BITS);

    typedef struct packed {
        scan_st_e          st;
        logic [ADDR_W-1:0] pos;
        logic              done;
    } scan_t;

    scan_t s_d, s_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        launch_o = 1'b0;
        eff_len  = (len_i > MAX_LEN) ? MAX_LEN : len_i;
        case (s_q.st)
            SC_IDLE: begin
                if (start_i) begin
                    launch_o = 1'b1;
                    if (eff_len == '0) begin
                        s_d.st = SC_DRAIN;
                    end else begin
                        s_d.st  = SC_SCAN;
                        s_d.pos = ADDR_W'(eff_len - LEN_W'(1));
                    end
                end
            end
            SC_SCAN: begin
                if (s_q.pos == '0) begin
                    s_d.st = SC_DRAIN;
                end else begin
                    s_d.pos = s_q.pos - ADDR_W'(1);
                end
            end
            SC_DRAIN: begin
                if (quiet_i) begin
                    s_d.st   = SC_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SC_IDLE, pos: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o    = s_q.pos;
    assign rd_en_o   = (s_q.st == SC_SCAN);
    assign rd_last_o = (s_q.st == SC_SCAN) && (s_q.pos == '0);
    assign busy_o    = (s_q.st != SC_IDLE);
    assign done_o    = s_q.done;

endmodule

// File: rtl/swx_window.sv
module swx_window #(
    parameter int WIN   = 5,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic             bit_i,
    input  logic             last_i,
    output logic             zero_o,
    output logic             close_o,
    output logic [WIN-1:0]   val_o,
    output logic [CNT_W-1:0] tz_o
);

    localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(WIN);

    typedef struct packed {
        logic             active;
        logic [WIN-1:0]   bits;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lastone;
    } win_t;

    win_t w_d, w_q;
    logic [WIN-1:0]   nbits;
    logic [CNT_W-1:0] ncnt;
    logic [CNT_W-1:0] nlast;

    always_comb begin
        w_d     = w_q;
        zero_o  = 1'b0;
        close_o = 1'b0;
        val_o   = '0;
        tz_o    = '0;
        nbits   = '0;
        ncnt    = '0;
        nlast   = '0;
        if (rd_en_i && !w_q.active && !bit_i) begin
            zero_o = 1'b1;
        end
        if (rd_en_i && (w_q.active || bit_i)) begin
            if (w_q.active) begin
                nbits = {w_q.bits[WIN-2:0], bit_i};
                ncnt  = w_q.cnt + CNT_W'(1);
                nlast = bit_i ? ncnt : w_q.lastone;
            end else begin
                nbits = WIN'(1);
                ncnt  = CNT_W'(1);
                nlast = CNT_W'(1);
            end
            if ((ncnt == WIN_CNT) || last_i) begin
                close_o    = 1'b1;
                tz_o       = ncnt - nlast;
                val_o      = nbits >> tz_o;
                w_d.active = 1'b0;
            end else begin
                w_d.active  = 1'b1;
                w_d.bits    = nbits;
                w_d.cnt     = ncnt;
                w_d.lastone = nlast;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/swx_emit.sv
module swx_emit #(
    parameter int WIN    = 5,
    parameter int CNT_W  = $clog2(WIN + 1),
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              zero_i,
    input  logic              close_i,
    input  logic [WIN-1:0]    val_i,
    input  logic [CNT_W-1:0]  tz_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WIN-1:0]    data_o,
    output logic [LEN_W-1:0]  count_o,
    output logic              quiet_o,
    output logic [CNT_W-1:0]  pend_o,
    output logic              held_o
);

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic             held;
        logic [WIN-1:0]   hval;
        logic [CNT_W-1:0] htz;
        logic [LEN_W-1:0] waddr;
    } emit_t;

    emit_t e_d, e_q;
    logic [CNT_W:0] pend_in;

    always_comb begin
        e_d     = e_q;
        we_o    = 1'b0;
        data_o  = '0;
        pend_in = {1'b0, e_q.pend} + (CNT_W + 1)'(zero_i);
        if (close_i) begin
            we_o = 1'b1;
            if (e_q.pend == '0) begin
                data_o   = val_i;
                e_d.pend = tz_i;
            end else begin
                e_d.pend = e_q.pend - CNT_W'(1);
                e_d.held = 1'b1;
                e_d.hval = val_i;
                e_d.htz  = tz_i;
            end
        end else if (e_q.held) begin
            we_o = 1'b1;
            if (e_q.pend == '0) begin
                data_o   = e_q.hval;
                e_d.pend = e_q.htz;
                e_d.held = 1'b0;
            end else begin
                e_d.pend = e_q.pend - CNT_W'(1);
            end
        end else if (pend_in != '0) begin
            we_o     = 1'b1;
            e_d.pend = CNT_W'(pend_in - (CNT_W + 1)'(1));
        end
        if (we_o) begin
            e_d.waddr = e_q.waddr + LEN_W'(1);
        end
        if (launch_i) begin
            e_d.waddr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign addr_o  = e_q.waddr[ADDR_W-1:0];
    assign count_o = e_q.waddr;
    assign quiet_o = (e_q.pend == '0) && !e_q.held;
    assign pend_o  = e_q.pend;
    assign held_o  = e_q.held;

endmodule

// File: rtl/swx_encoder.sv
module swx_encoder #(
    parameter int MAX_BITS = 2048,
    parameter int WIN      = 5,
    parameter int LEN_W    = $clog2(MAX_BITS + 1),
    parameter int ADDR_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  exp_len,
    output logic [ADDR_W-1:0] exp_addr,
    input  logic              exp_bit,
    output logic              busy,
    output logic              done,
    output logic              tok_we,
    output logic [ADDR_W-1:0] tok_addr,
    output logic [WIN-1:0]    tok_data,
    output logic [LEN_W-1:0]  tok_count
);

    localparam int CNT_W = $clog2(WIN + 1);

    logic             rd_en;
    logic             rd_last;
    logic             launch;
    logic             quiet;
    logic             sq_zero;
    logic             win_close;
    logic [WIN-1:0]   win_val;
    logic [CNT_W-1:0] win_tz;
    logic [CNT_W-1:0] pend;
    logic             held;

    swx_scan #(
        .MAX_BITS(MAX_BITS),
        .LEN_W   (LEN_W),
        .ADDR_W  (ADDR_W)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .len_i    (exp_len),
        .quiet_i  (quiet),
        .addr_o   (exp_addr),
        .rd_en_o  (rd_en),
        .rd_last_o(rd_last),
        .launch_o (launch),
        .busy_o   (busy),
        .done_o   (done)
    );

    swx_window #(
        .WIN  (WIN),
        .CNT_W(CNT_W)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en_i(rd_en),
        .bit_i  (exp_bit),
        .last_i (rd_last),
        .zero_o (sq_zero),
        .close_o(win_close),
        .val_o  (win_val),
        .tz_o   (win_tz)
    );

    swx_emit #(
        .WIN   (WIN),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .zero_i  (sq_zero),
        .close_i (win_close),
        .val_i   (win_val),
        .tz_i    (win_tz),
        .we_o    (tok_we),
        .addr_o  (tok_addr),
        .data_o  (tok_data),
        .count_o (tok_count),
        .quiet_o (quiet),
        .pend_o  (pend),
        .held_o  (held)
    );

endmodule

// File: rtl/swx_encoder_chk.sv
module swx_encoder_chk #(
    parameter int WIN    = 5,
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] exp_addr,
    input logic              tok_we,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [WIN-1:0]    tok_data,
    input logic [CNT_W-1:0]  pend,
    input logic              held,
    input logic              win_close
);

    a_r2_addr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (exp_addr == $past(exp_addr) - ADDR_W'(1)));

    a_r4_window_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_we && (tok_data != '0)) |-> tok_data[0]);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_we && $past(tok_we) && busy && $past(busy)) |-> (tok_addr == $past(tok_addr) + ADDR_W'(1)));

    a_r6_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tok_we);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && pend == '0 && !held));

    a_r11_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CNT_W'(WIN - 1));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !win_close);

endmodule

bind swx_encoder swx_encoder_chk #(
    .WIN   (WIN),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rd_en    (rd_en),
    .exp_addr (exp_addr),
    .tok_we   (tok_we),
    .tok_addr (tok_addr),
    .tok_data (tok_data),
    .pend     (pend),
    .held     (held),
    .win_close(win_close)
);

// File: tb/sim_swx_encoder.sv
module sim_swx_encoder;

    localparam int MAX_BITS = 2048;
    localparam int WIN      = 5;
    localparam int LEN_W    = 12;
    localparam int ADDR_W   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  exp_len = '0;
    logic [ADDR_W-1:0] exp_addr;
    logic              exp_bit;
    logic              busy;
    logic              done;
    logic              tok_we;
    logic [ADDR_W-1:0] tok_addr;
    logic [WIN-1:0]    tok_data;
    logic [LEN_W-1:0]  tok_count;

    logic [MAX_BITS-1:0] ex = '0;
    int n_chk = 0;
    int n_err = 0;
    int ref_q[$];

    always #2 clk = ~clk;

    assign exp_bit = ex[exp_addr];

    swx_encoder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .exp_len  (exp_len),
        .exp_addr (exp_addr),
        .exp_bit  (exp_bit),
        .busy     (busy),
        .done     (done),
        .tok_we   (tok_we),
        .tok_addr (tok_addr),
        .tok_data (tok_data),
        .tok_count(tok_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Queue model: square for 0, otherwise longest odd string of <= WIN bits.
    task automatic build_ref(input int eff);
        int i;
        int lo;
        int v;
        ref_q.delete();
        i = eff - 1;
        while (i >= 0) begin
            if (ex[i] == 1'b0) begin
                ref_q.push_back(0);
                i--;
            end else begin
                lo = (i - WIN + 1 < 0) ? 0 : i - WIN + 1;
                while (ex[lo] == 1'b0) lo++;
                v = 0;
                for (int b = i; b >= lo; b--) v = v * 2 + int'(ex[b]);
                ref_q.push_back(v);
                i = lo - 1;
            end
        end
    endtask

    task automatic run(input int len_req, input int ignore_at);
        int eff;
        int nw;
        int p;
        int mism;
        int ln;
        int expv;
        bit seen_done;
        eff = (len_req > MAX_BITS) ? MAX_BITS : len_req;
        build_ref(eff);
        nw = 0;
        p = eff - 1;
        mism = 0;
        seen_done = 1'b0;
        start   = 1'b1;
        exp_len = LEN_W'(len_req);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= eff + 20; k++) begin
            start = 1'b0;
            if (k <= eff) begin
                chk(busy == 1'b1, "R1 busy during scan", int'(busy), 1);
                chk(int'(exp_addr) == eff - k, "R2 address order", int'(exp_addr), eff - k);
            end
            if (tok_we) begin
                chk(int'(tok_addr) == nw, "R6 token address", int'(tok_addr), nw);
                if (ref_q.size() == 0) begin
                    chk(1'b0, "R5 extra token", int'(tok_data), -1);
                end else begin
                    expv = ref_q.pop_front();
                    chk(int'(tok_data) == expv, (expv == 0) ? "R3 square token" : "R4 window token",
                        int'(tok_data), expv);
                end
                if (tok_data == '0) begin
                    if (p < 0 || ex[p] != 1'b0) mism++;
                    p--;
                end else begin
                    ln = 0;
                    for (int b = 0; b < WIN; b++) if (tok_data[b]) ln = b + 1;
                    for (int b = ln - 1; b >= 0; b--) begin
                        if (p < 0 || ex[p] != tok_data[b]) mism++;
                        p--;
                    end
                end
                nw++;
            end
            if (seen_done) begin
                chk(done == 1'b0, "R7 done single pulse", int'(done), 0);
                break;
            end
            if (done) begin
                seen_done = 1'b1;
                chk(k <= eff + 8, "R7 done latency", k, eff + 8);
                chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
                chk(int'(tok_count) == nw, "R7 token count", int'(tok_count), nw);
                chk(ref_q.size() == 0, "R5 tokens missing", ref_q.size(), 0);
                chk(mism == 0 && p == -1, "R5 reconstruction", mism, 0);
            end
            if (k == ignore_at) begin
                start   = 1'b1;
                exp_len = LEN_W'(3);
            end
            @(negedge clk);
        end
        chk(seen_done, "R7 done seen", int'(seen_done), 1);
    endtask

    task automatic fill_random(input int len);
        ex = '0;
        for (int b = 0; b < len; b++) ex[b] = 1'($urandom_range(0, 1));
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R7 reset done", int'(done), 0);
        chk(tok_we == 1'b0, "R6 reset write", int'(tok_we), 0);
        chk(tok_count == '0, "R6 reset count", int'(tok_count), 0);

        ex = '0;                 run(16, 0);    // R3 all zeros
        ex = '0; ex[22:0] = '1;  run(23, 0);    // R4 full windows then cut
        ex = '0; ex[0] = 1'b1;   run(1, 0);     // R10 one-bit window
        ex = '0; ex[1:0] = 2'b11; run(2, 0);    // R10 cut to 2 bits
        ex = '0; ex[6:0] = 7'b1000001; run(7, 0);  // R11 held window at the end
        ex = '0; ex[5:0] = 6'b110000;  run(6, 0);  // R4 trailing zeros after window
        run(0, 0);                              // R8 empty exponent
        fill_random(100); run(100, 0);
        fill_random(333); run(333, 50);         // R1 start while busy
        fill_random(517); run(517, 0);
        fill_random(2048); run(2048, 0);
        fill_random(2048); run(4095, 0);        // R9 clamp

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule